// File: doc/BRIEF.md
# Time-shared RGB to luma/colour-difference converter

This block is the last stage of a pixel pipeline that keeps colour in RGB form. It turns each 8-bit RGB pixel into one luma value and two colour-difference values for a composite video encoder. A mode input selects the coefficient set. Mode 0 gives analog-style YUV. Mode 1 gives digital YCbCr with studio offsets. The arithmetic path is the same in both modes; only the coefficient set differs.

The block runs on a fast clock at three times the pixel rate. A single dot-product multiply-accumulate unit is shared by the three output components. It computes luma, then the first colour difference, then the second, one per fast cycle. Pixels enter through a valid/ready handshake that accepts at most one pixel every three cycles. The three results leave together as a registered triple, marked by a one-cycle valid pulse.

Top module: `csc_serial`

## Requirements
- R1: While reset is asserted, `out_valid_o` is 0, `in_ready_o` is 1 and all three result outputs are 0.
- R2: A pixel is taken on a clock edge where `in_valid_i` and `in_ready_o` are both 1. After such an edge, `in_ready_o` is 0 for exactly two cycles and is then 1 again.
- R3: A taken pixel produces its results on the fourth rising edge after the edge that took it. `out_valid_o` is 1 for that one cycle only, and there is exactly one pulse per pixel, in order.
- R4: In mode 0, luma is (77R + 150G + 29B + 128) >> 8, where >> is an arithmetic (floor) shift. First difference U uses (-38, -74, 112) and second difference V uses (157, -132, -25), with the same rounding. No luma offset is added.
- R5: In mode 1, luma uses (66, 129, 25), Cb uses (-38, -74, 112) and Cr uses (112, -94, -18). 16 is added to the rounded luma, so white gives 235 and black gives 16.
- R6: In both modes, 128 is added to each rounded colour-difference value, so any grey gives 128 on both chroma outputs.
- R7: Every result is clamped to 0..255 after the offset is added. For example, pure red in mode 0 gives V = 255, and pure green in mode 0 gives V = 0.
- R8: The mode is captured when a pixel is taken. Changing `ycc_mode_i` while that pixel is being computed does not change any of its three results.
- R9: The result outputs change only in a cycle where `out_valid_o` is 1; otherwise they hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, three times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ycc_mode_i | input | 1 | 0 = YUV coefficients, 1 = YCbCr coefficients with offsets |
| in_valid_i | input | 1 | Input pixel is present |
| in_ready_o | output | 1 | Block can take a pixel this cycle |
| r_i | input | PIX_W | Red component |
| g_i | input | PIX_W | Green component |
| b_i | input | PIX_W | Blue component |
| out_valid_o | output | 1 | One-cycle pulse: a new result triple is on the outputs |
| y_o | output | PIX_W | Luma |
| c1_o | output | PIX_W | First colour difference (U or Cb) |
| c2_o | output | PIX_W | Second colour difference (V or Cr) |

## Verification
The hardest case to reach is a mode change that lands while a pixel is still in flight. The change must also fall in the same cycle that a following pixel is taken with the other coefficient set. In that cycle the second-difference result of the old pixel and the luma of the new pixel sit next to each other in the pipeline. The stimulus streams pixels back to back with the mode alternating on every pixel, and it flips the mode input on every idle cycle in between. The reference model fixes each pixel's coefficient set at the edge that took it. Any mixing of coefficient sets then shows up as a mismatch, and saturating colours in both modes drive every clamp limit.

// File: rtl/csc_pkg.sv
package csc_pkg;

  // Component order in which the shared unit visits a pixel.
  typedef enum logic [1:0] {
    PH_LUMA = 2'd0,
    PH_CB   = 2'd1,
    PH_CR   = 2'd2
  } phase_e;

  localparam int NUM_CH = 3;  // channel 0 = red, 1 = green, 2 = blue

  // Coefficient for (mode, component, channel), scaled by 256.
  function automatic int coef_q8(input logic ycc, input phase_e ph, input int ch);
    int k;
    k = 0;
    if (!ycc) begin
      case (ph)
        PH_LUMA: k = (ch == 0) ? 77   : (ch == 1) ? 150  : 29;
        PH_CB:   k = (ch == 0) ? -38  : (ch == 1) ? -74  : 112;
        default: k = (ch == 0) ? 157  : (ch == 1) ? -132 : -25;
      endcase
    end else begin
      case (ph)
        PH_LUMA: k = (ch == 0) ? 66   : (ch == 1) ? 129  : 25;
        PH_CB:   k = (ch == 0) ? -38  : (ch == 1) ? -74  : 112;
        default: k = (ch == 0) ? 112  : (ch == 1) ? -94  : -18;
      endcase
    end
    return k;
  endfunction

  // Offset added to the rounded luma.
  function automatic int luma_offset(input logic ycc, input int pix_w);
    return ycc ? (16 << (pix_w - 8)) : 0;
  endfunction

  // Mid-scale offset added to both colour differences.
  function automatic int chroma_mid(input int pix_w);
    return 1 << (pix_w - 1);
  endfunction

endpackage

// File: rtl/csc_seq.sv
module csc_seq
  import csc_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid_i,
  input  logic                    mode_i,
  input  logic [NUM_CH*PIX_W-1:0] pix_i,
  output logic                    in_ready_o,
  output logic                    accept_o,
  output logic                    busy_o,
  output logic                    last_o,
  output phase_e                  phase_o,
  output logic [NUM_CH*PIX_W-1:0] pix_o,
  output logic                    mode_o
);

  logic   busy_q;
  phase_e phase_q;

  // Ready when idle or in the final phase of the current pixel.
  assign last_o     = busy_q && (phase_q == PH_CR);
  assign in_ready_o = !busy_q || last_o;
  assign accept_o   = in_valid_i && in_ready_o;
  assign busy_o     = busy_q;
  assign phase_o    = phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      phase_q <= PH_LUMA;
      pix_o   <= '0;
      mode_o  <= 1'b0;
    end else if (accept_o) begin
      busy_q  <= 1'b1;
      phase_q <= PH_LUMA;
      pix_o   <= pix_i;
      mode_o  <= mode_i;
    end else if (busy_q) begin
      if (phase_q == PH_CR) begin
        busy_q  <= 1'b0;
        phase_q <= PH_LUMA;
      end else begin
        phase_q <= phase_e'(phase_q + 2'd1);
      end
    end
  end

endmodule

// File: rtl/csc_coef.sv
module csc_coef
  import csc_pkg::*;
#(
  parameter int COEF_W = 10,
  parameter int FRAC_W = 8
) (
  input  logic                     ycc_i,
  input  phase_e                   phase_i,
  output logic [NUM_CH*COEF_W-1:0] k_o
);

  localparam int SCALE_SH = FRAC_W - 8;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_k
    always_comb begin
      k_o[c*COEF_W +: COEF_W] = COEF_W'(coef_q8(ycc_i, phase_i, c) <<< SCALE_SH);
    end
  end

endmodule

// File: rtl/csc_mac.sv
module csc_mac
  import csc_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 10,
  parameter int FRAC_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     step_i,
  input  phase_e                   phase_i,
  input  logic                     ycc_i,
  input  logic [NUM_CH*PIX_W-1:0]  pix_i,
  input  logic [NUM_CH*COEF_W-1:0] k_i,
  output logic                     commit_o,
  output logic                     out_valid_o,
  output logic [PIX_W-1:0]         y_o,
  output logic [PIX_W-1:0]         c1_o,
  output logic [PIX_W-1:0]         c2_o
);

  localparam int ACC_W = PIX_W + COEF_W + 3;
  localparam logic signed [ACC_W-1:0] HALF    = ACC_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [ACC_W-1:0] PIX_MAX = ACC_W'((1 << PIX_W) - 1);

  logic signed [ACC_W-1:0] prod [NUM_CH];
  logic signed [ACC_W-1:0] sum_w;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_prod
    assign prod[c] = ACC_W'($signed(k_i[c*COEF_W +: COEF_W]))
                   * ACC_W'($signed({1'b0, pix_i[c*PIX_W +: PIX_W]}));
  end

  always_comb begin
    sum_w = '0;
    for (int c = 0; c < NUM_CH; c++) sum_w = sum_w + prod[c];
  end

  // Round to nearest (ties up), add offset, clamp to the pixel range.
  function automatic logic [PIX_W-1:0] round_clamp(input logic signed [ACC_W-1:0] acc,
                                                   input int off);
    logic signed [ACC_W-1:0] v;
    v = (acc + HALF) >>> FRAC_W;
    v = v + ACC_W'(off);
    if (v[ACC_W-1]) return '0;
    if (v > PIX_MAX) return '1;
    return v[PIX_W-1:0];
  endfunction

  // Stage 1: accumulated dot product of one component.
  logic signed [ACC_W-1:0] acc_q;
  phase_e                  acc_ph_q;
  logic                    acc_ycc_q;
  logic                    acc_v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      acc_ph_q  <= PH_LUMA;
      acc_ycc_q <= 1'b0;
      acc_v_q   <= 1'b0;
    end else begin
      acc_v_q <= step_i;
      if (step_i) begin
        acc_q     <= sum_w;
        acc_ph_q  <= phase_i;
        acc_ycc_q <= ycc_i;
      end
    end
  end

  // Stage 2: finish each component; publish the triple on the last one.
  int               off_w;
  logic [PIX_W-1:0] fin_w;

  always_comb begin
    off_w = (acc_ph_q == PH_LUMA) ? luma_offset(acc_ycc_q, PIX_W) : chroma_mid(PIX_W);
    fin_w = round_clamp(acc_q, off_w);
  end

  assign commit_o = acc_v_q && (acc_ph_q == PH_CR);

  logic [PIX_W-1:0] y_hold_q, c1_hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_hold_q    <= '0;
      c1_hold_q   <= '0;
      y_o         <= '0;
      c1_o        <= '0;
      c2_o        <= '0;
      out_valid_o <= 1'b0;
    end else begin
      out_valid_o <= commit_o;
      if (acc_v_q && acc_ph_q == PH_LUMA) y_hold_q  <= fin_w;
      if (acc_v_q && acc_ph_q == PH_CB)   c1_hold_q <= fin_w;
      if (commit_o) begin
        y_o  <= y_hold_q;
        c1_o <= c1_hold_q;
        c2_o <= fin_w;
      end
    end
  end

endmodule

// File: rtl/csc_serial.sv
module csc_serial
  import csc_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int COEF_W = 10,
  parameter int FRAC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ycc_mode_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [PIX_W-1:0] r_i,
  input  logic [PIX_W-1:0] g_i,
  input  logic [PIX_W-1:0] b_i,
  output logic             out_valid_o,
  output logic [PIX_W-1:0] y_o,
  output logic [PIX_W-1:0] c1_o,
  output logic [PIX_W-1:0] c2_o
);

  // Named internal events, used by the bound checker.
  logic                     accept_w;
  logic                     busy_w;
  logic                     last_w;
  logic                     mode_q_w;
  logic                     commit_w;
  phase_e                   phase_w;
  logic [NUM_CH*PIX_W-1:0]  pix_held_w;
  logic [NUM_CH*COEF_W-1:0] coef_w;

  csc_seq #(.PIX_W(PIX_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid_i (in_valid_i),
    .mode_i     (ycc_mode_i),
    .pix_i      ({b_i, g_i, r_i}),
    .in_ready_o (in_ready_o),
    .accept_o   (accept_w),
    .busy_o     (busy_w),
    .last_o     (last_w),
    .phase_o    (phase_w),
    .pix_o      (pix_held_w),
    .mode_o     (mode_q_w)
  );

  csc_coef #(.COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_coef (
    .ycc_i   (mode_q_w),
    .phase_i (phase_w),
    .k_o     (coef_w)
  );

  csc_mac #(.PIX_W(PIX_W), .COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_mac (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_i      (busy_w),
    .phase_i     (phase_w),
    .ycc_i       (mode_q_w),
    .pix_i       (pix_held_w),
    .k_i         (coef_w),
    .commit_o    (commit_w),
    .out_valid_o (out_valid_o),
    .y_o         (y_o),
    .c1_o        (c1_o),
    .c2_o        (c2_o)
  );

endmodule

// File: rtl/csc_serial_chk.sv
module csc_serial_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic [PIX_W-1:0] y,
  input logic [PIX_W-1:0] c1,
  input logic [PIX_W-1:0] c2,
  input logic             accept,
  input logic             busy,
  input logic             last,
  input logic             mode_q,
  input logic             commit
);

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  // R2
  ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ##1 !in_ready);

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R3
  commit_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(last, 2));

  // R3
  commit_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> out_valid);

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !accept) |=> $stable(mode_q));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({y, c1, c2}) |-> out_valid);

endmodule

bind csc_serial csc_serial_chk #(.PIX_W(PIX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready_o),
  .out_valid (out_valid_o),
  .y         (y_o),
  .c1        (c1_o),
  .c2        (c2_o),
  .accept    (accept_w),
  .busy      (busy_w),
  .last      (last_w),
  .mode_q    (mode_q_w),
  .commit    (commit_w)
);

// File: tb/csc_serial_tb_top.sv
module csc_serial_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ycc = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] r = '0, g = '0, b = '0;
  logic       in_ready, out_valid;
  logic [7:0] y, c1, c2;

  always #5 clk = ~clk;

  csc_serial dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ycc_mode_i  (ycc),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .r_i         (r),
    .g_i         (g),
    .b_i         (b),
    .out_valid_o (out_valid),
    .y_o         (y),
    .c1_o        (c1),
    .c2_o        (c2)
  );

  typedef struct {
    int due;
    bit in_r8;
    bit ycc;
    int ey;
    int e1;
    int e2;
  } exp_t;

  exp_t q[$];
  int   checks = 0, errors = 0, cyc = 0, since = 3;
  bit   exp_ready = 1'b1, r8_sec = 1'b0, done = 1'b0;
  int   last_y = 0, last_c1 = 0, last_c2 = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Independent arithmetic: weights per row, floor shift, offset, clamp.
  function automatic int ref_comp(input bit m, input int comp, input int rr, input int gg, input int bb);
    int w[3];
    int s;
    if (comp == 0) w = m ? '{66, 129, 25} : '{77, 150, 29};
    else if (comp == 1) w = '{-38, -74, 112};
    else w = m ? '{112, -94, -18} : '{157, -132, -25};
    s = w[0] * rr + w[1] * gg + w[2] * bb;
    s = (s + 128) >>> 8;
    s = s + ((comp == 0) ? (m ? 16 : 0) : 128);
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  function automatic string tag(input int comp, input bit m, input int e, input bit in_r8);
    if (in_r8) return "R8";
    if (e == 0 || e == 255) return "R7";
    if (comp != 0) return "R6";
    return m ? "R5" : "R4";
  endfunction

  // Model runs 2 ns after each rising edge, compared every cycle.
  always @(posedge clk) begin
    #2;
    if (!rst_n) begin
      q.delete();
      since = 3;
      exp_ready = 1'b1;
      last_y = 0; last_c1 = 0; last_c2 = 0;
    end else begin
      cyc++;
      if (in_valid && exp_ready) begin
        exp_t e;
        e.due   = cyc + 4;
        e.in_r8 = r8_sec;
        e.ycc   = ycc;
        e.ey    = ref_comp(ycc, 0, r, g, b);
        e.e1    = ref_comp(ycc, 1, r, g, b);
        e.e2    = ref_comp(ycc, 2, r, g, b);
        q.push_back(e);
        since = 0;
      end else if (since < 3) begin
        since++;
      end
      exp_ready = (since >= 2);
      chk(in_ready === exp_ready, "R2", "in_ready", in_ready, exp_ready);
      if (q.size() > 0 && q[0].due == cyc) begin
        chk(out_valid === 1'b1, "R3", "out_valid", out_valid, 1);
        chk(y  === 8'(q[0].ey), tag(0, q[0].ycc, q[0].ey, q[0].in_r8), "luma", y, q[0].ey);
        chk(c1 === 8'(q[0].e1), tag(1, q[0].ycc, q[0].e1, q[0].in_r8), "diff1", c1, q[0].e1);
        chk(c2 === 8'(q[0].e2), tag(2, q[0].ycc, q[0].e2, q[0].in_r8), "diff2", c2, q[0].e2);
        last_y = q[0].ey; last_c1 = q[0].e1; last_c2 = q[0].e2;
        void'(q.pop_front());
      end else begin
        chk(out_valid === 1'b0, "R3", "out_valid idle", out_valid, 0);
        chk(y === 8'(last_y) && c1 === 8'(last_c1) && c2 === 8'(last_c2),
            "R9", "held luma", y, last_y);
      end
    end
  end

  task automatic push(input bit m, input int rr, input int gg, input int bb);
    bit ok;
    ycc = m; r = 8'(rr); g = 8'(gg); b = 8'(bb); in_valid = 1'b1;
    do begin
      ok = in_ready;
      @(negedge clk);
    end while (!ok);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state held in reset
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R1", "reset valid/ready", out_valid, 0);
    chk(y === 8'd0 && c1 === 8'd0 && c2 === 8'd0, "R1", "reset outputs", y, 0);
    rst_n = 1'b1;
    idle(2);

    // R4 R5 R6 R7: corner colours in both modes, streamed back to back (R2)
    for (int m = 0; m < 2; m++) begin
      push(m[0], 0, 0, 0);
      push(m[0], 255, 255, 255);
      push(m[0], 255, 0, 0);
      push(m[0], 0, 255, 0);
      push(m[0], 0, 0, 255);
      push(m[0], 128, 128, 128);
      push(m[0], 128, 64, 200);
    end
    idle(6);

    // R8: mode flips during every computation and on every pixel
    r8_sec = 1'b1;
    for (int i = 0; i < 12; i++) begin
      push(i[0], 255 - i * 20, 30 + i * 18, (i * 53) % 256);
      ycc = ~ycc;
      if (i % 3 == 2) begin
        idle(1);
        ycc = ~ycc;
        idle(1);
      end
    end
    r8_sec = 1'b0;
    idle(6);

    // Random pixels, random modes, random gaps
    for (int i = 0; i < 300; i++) begin
      if ($urandom % 4 == 0) idle(1 + $urandom % 3);
      push(1'($urandom), int'($urandom % 256), int'($urandom % 256), int'($urandom % 256));
    end
    idle(10);
    // R3: every accepted pixel has produced its result
    chk(q.size() == 0, "R3", "pending results", q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R3 actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule